// File: doc/BRIEF.md
# Open-Row Buffer Controller for a Slow-Write Memory Bank

This block fronts one bank of a memory whose array writes are slow and costly compared with its reads. It keeps one row open in a local buffer, serves 64-byte read and write requests from that buffer, and touches the array only when it must. Sensing a row does not disturb the array, so the array still holds every block that was not modified while the row was open. When a row is closed, only the blocks that were modified go back to the array. A row in which nothing was modified costs no array write at all.

Each 64-byte block of the open row carries its own modified flag. A request to another row closes the open one and then senses the new row block by block. A bypass mode sends writes straight to the array without opening their row. If the written row happens to be the open one, the buffered copy is kept in step. The array is modelled as two independent valid/ready ports, one for sensing and one for writing, with no further timing.

Top module: `nvm_rowbuf_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `awr_valid` and `sns_valid` are 0. No row is open, so the first request of any kind that is not a bypass write starts sensing without any array write.
- R2: A read of a block in the open row raises `rsp_valid` for exactly one cycle, one cycle after acceptance, with the buffered data. It causes no sense and no array write.
- R3: A write to the open row with `bypass_mode` at 0 updates the buffered block and marks it modified, with no array access. A later read of that block returns the new data.
- R4: A request that misses while the open row holds no modified block issues no array write. `sns_valid` rises in the cycle after acceptance.
- R5: On a miss with modified blocks, exactly those blocks are written to the array. They go in ascending block index order, one per `awr_valid`/`awr_ready` handshake, with the old row address and the buffered data. Address and data hold steady while `awr_ready` is low.
- R6: Sensing of the new row begins only after the last write-back handshake. `sns_valid` and `awr_valid` are never high together.
- R7: Sensing reads all 32 blocks, indices 0 to 31 in ascending order, one per `sns_valid`/`sns_ready` handshake. A read miss then raises `rsp_valid` two cycles after the final sense handshake, with the sensed data of the requested block.
- R8: A write miss with `bypass_mode` at 0 first opens the row and then merges the write into the buffer, marking that block modified. It is later written back when that row closes.
- R9: A write accepted with `bypass_mode` at 1 issues one array write carrying its own row, block and data, and no sensing. It does not change which row is open. If its row is open, the buffered block takes the new data and the block's modified flag is cleared.
- R10: `req_ready` is 0 whenever `awr_valid` or `sns_valid` is 1. No request is accepted while a write-back, a sense or a bypass write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_mode | input | 1 | Write requests go straight to the array when 1 (sampled on acceptance) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 14 | Row address of the request |
| req_blk | input | 5 | 64-byte block index within the row |
| req_wdata | input | 512 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 512 | Read response data |
| sns_valid | output | 1 | Array sense request valid |
| sns_ready | input | 1 | Array sense done; `sns_rdata` valid |
| sns_row | output | 14 | Row being sensed |
| sns_blk | output | 5 | Block being sensed |
| sns_rdata | input | 512 | Sensed block data |
| awr_valid | output | 1 | Array write request valid |
| awr_ready | input | 1 | Array write accepted |
| awr_row | output | 14 | Array write row |
| awr_blk | output | 5 | Array write block |
| awr_wdata | output | 512 | Array write data |

## Verification
A read hit is due exactly one cycle after the acceptance cycle. On a clean miss, sensing starts one cycle after acceptance, and the read data follows two cycles after the last sense handshake. Write hits and bypass hits are due at once, and are judged through a following read hit that must again answer in one cycle. The bench records the acceptance cycle and every handshake cycle on the falling clock edge, then compares each result against those recorded cycles and against a logged array model. Write-back order, the set of blocks written back and the absence of overlap with sensing are checked from that log.

// File: rtl/nvrb_pkg.sv
package nvrb_pkg;

    parameter int unsigned NVRB_ROW_W  = 14;
    parameter int unsigned NVRB_BLKS   = 32;
    parameter int unsigned NVRB_DATA_W = 512;
    localparam int unsigned NVRB_IDX_W = $clog2(NVRB_BLKS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_DONE,
        ST_BYP
    } nvrb_state_e;

    typedef struct packed {
        logic                    is_wr;
        logic                    byp;
        logic [NVRB_ROW_W-1:0]   row;
        logic [NVRB_IDX_W-1:0]   blk;
        logic [NVRB_DATA_W-1:0]  data;
    } nvrb_op_t;

endpackage

// File: rtl/nvrb_blk_counter.sv
module nvrb_blk_counter #(
    parameter int unsigned BLKS  = nvrb_pkg::NVRB_BLKS,
    localparam int unsigned IDX_W = $clog2(BLKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [IDX_W-1:0] cnt,
    output logic             last
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(BLKS - 1);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == TOP);

    // R7
    fill_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && last) |=> (cnt == '0))
        else $error("fill counter did not wrap after last block");
endmodule

// File: rtl/nvrb_dirty_track.sv
module nvrb_dirty_track #(
    parameter int unsigned BLKS  = nvrb_pkg::NVRB_BLKS,
    localparam int unsigned IDX_W = $clog2(BLKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_all,
    output logic             any,
    output logic             single,
    output logic [IDX_W-1:0] first_idx
);
    logic [BLKS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            mask_q <= '0;
        end else begin
            if (clr_en) mask_q[clr_idx] <= 1'b0;
            if (set_en) mask_q[set_idx] <= 1'b1;
        end
    end

    always_comb begin
        first_idx = '0;
        for (int i = BLKS - 1; i >= 0; i--) begin
            if (mask_q[i]) first_idx = IDX_W'(i);
        end
    end

    assign any    = |mask_q;
    assign single = any && ((mask_q & (mask_q - 1'b1)) == '0);

    // R5
    wb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en && !clr_all) |=> !mask_q[$past(clr_idx)])
        else $error("cleared block still marked modified");
endmodule

// File: rtl/nvrb_row_store.sv
module nvrb_row_store #(
    parameter int unsigned BLKS   = nvrb_pkg::NVRB_BLKS,
    parameter int unsigned DATA_W = nvrb_pkg::NVRB_DATA_W,
    localparam int unsigned IDX_W = $clog2(BLKS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DATA_W-1:0] mem_q [BLKS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_a_data = mem_q[rd_a_idx];
    assign rd_b_data = mem_q[rd_b_idx];
endmodule

// File: rtl/nvm_rowbuf_ctrl.sv
module nvm_rowbuf_ctrl
    import nvrb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bypass_mode,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [NVRB_ROW_W-1:0]   req_row,
    input  logic [NVRB_IDX_W-1:0]   req_blk,
    input  logic [NVRB_DATA_W-1:0]  req_wdata,
    output logic                    rsp_valid,
    output logic [NVRB_DATA_W-1:0]  rsp_rdata,
    output logic                    sns_valid,
    input  logic                    sns_ready,
    output logic [NVRB_ROW_W-1:0]   sns_row,
    output logic [NVRB_IDX_W-1:0]   sns_blk,
    input  logic [NVRB_DATA_W-1:0]  sns_rdata,
    output logic                    awr_valid,
    input  logic                    awr_ready,
    output logic [NVRB_ROW_W-1:0]   awr_row,
    output logic [NVRB_IDX_W-1:0]   awr_blk,
    output logic [NVRB_DATA_W-1:0]  awr_wdata
);
    nvrb_state_e              state_q;
    nvrb_op_t                 op_q;
    logic [NVRB_ROW_W-1:0]    open_row_q;
    logic                     open_vld_q;
    logic                     rsp_valid_q;
    logic [NVRB_DATA_W-1:0]   rsp_data_q;

    logic                     accept, hit, awr_fire, sns_fire;
    logic                     dirty_any, dirty_single;
    logic [NVRB_IDX_W-1:0]    dirty_first;
    logic                     d_set, d_clr;
    logic [NVRB_IDX_W-1:0]    d_set_idx, d_clr_idx;
    logic                     fill_last;
    logic [NVRB_IDX_W-1:0]    fill_idx;
    logic                     bw_en;
    logic [NVRB_IDX_W-1:0]    bw_idx, rd_a_idx;
    logic [NVRB_DATA_W-1:0]   bw_data, rd_a_data, rd_b_data;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit       = open_vld_q && (req_row == open_row_q);
    assign awr_valid = (state_q == ST_WB) || (state_q == ST_BYP);
    assign sns_valid = (state_q == ST_FILL);
    assign awr_fire  = awr_valid && awr_ready;
    assign sns_fire  = sns_valid && sns_ready;

    assign awr_row   = (state_q == ST_BYP) ? op_q.row  : open_row_q;
    assign awr_blk   = (state_q == ST_BYP) ? op_q.blk  : dirty_first;
    assign awr_wdata = (state_q == ST_BYP) ? op_q.data : rd_b_data;
    assign sns_row   = op_q.row;
    assign sns_blk   = fill_idx;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_data_q;
    assign rd_a_idx  = (state_q == ST_DONE) ? op_q.blk : req_blk;

    // buffer write port: hit write, sensed block, or merged miss write
    always_comb begin
        bw_en   = 1'b0;
        bw_idx  = req_blk;
        bw_data = req_wdata;
        if (accept && req_write && hit) begin
            bw_en = 1'b1;
        end else if (sns_fire) begin
            bw_en   = 1'b1;
            bw_idx  = fill_idx;
            bw_data = sns_rdata;
        end else if (state_q == ST_DONE && op_q.is_wr) begin
            bw_en   = 1'b1;
            bw_idx  = op_q.blk;
            bw_data = op_q.data;
        end
    end

    // modified-flag updates
    always_comb begin
        d_set     = 1'b0;
        d_set_idx = req_blk;
        d_clr     = 1'b0;
        d_clr_idx = req_blk;
        if (accept && req_write && hit) begin
            d_set = !bypass_mode;
            d_clr = bypass_mode;
        end else if (state_q == ST_DONE && op_q.is_wr) begin
            d_set     = 1'b1;
            d_set_idx = op_q.blk;
        end else if (state_q == ST_WB && awr_fire) begin
            d_clr     = 1'b1;
            d_clr_idx = dirty_first;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= '0;
            open_row_q  <= '0;
            open_vld_q  <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q <= '{is_wr: req_write, byp: bypass_mode, row: req_row,
                              blk: req_blk, data: req_wdata};
                    if (req_write && bypass_mode) begin
                        state_q <= ST_BYP;
                    end else if (hit) begin
                        if (!req_write) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= rd_a_data;
                        end
                    end else if (dirty_any) begin
                        state_q <= ST_WB;
                    end else begin
                        state_q <= ST_FILL;
                    end
                end
                ST_WB: if (awr_fire && dirty_single) state_q <= ST_FILL;
                ST_FILL: if (sns_fire && fill_last) begin
                    open_row_q <= op_q.row;
                    open_vld_q <= 1'b1;
                    state_q    <= ST_DONE;
                end
                ST_DONE: begin
                    if (!op_q.is_wr) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= rd_a_data;
                    end
                    state_q <= ST_IDLE;
                end
                ST_BYP: if (awr_fire) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    nvrb_row_store #(.BLKS(NVRB_BLKS), .DATA_W(NVRB_DATA_W)) store_i (
        .clk(clk), .wr_en(bw_en), .wr_idx(bw_idx), .wr_data(bw_data),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(dirty_first), .rd_b_data(rd_b_data)
    );

    nvrb_dirty_track #(.BLKS(NVRB_BLKS)) dirty_i (
        .clk(clk), .rst(rst),
        .set_en(d_set), .set_idx(d_set_idx),
        .clr_en(d_clr), .clr_idx(d_clr_idx),
        .clr_all(sns_fire && fill_last),
        .any(dirty_any), .single(dirty_single), .first_idx(dirty_first)
    );

    nvrb_blk_counter #(.BLKS(NVRB_BLKS)) fill_i (
        .clk(clk), .rst(rst), .inc(sns_fire),
        .cnt(fill_idx), .last(fill_last)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !rsp_valid && !awr_valid && !sns_valid))
        else $error("not idle after reset");

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("response longer than one cycle");

    // R5
    awr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (awr_valid && !awr_ready) |=>
            (awr_valid && $stable(awr_blk) && $stable(awr_row) && $stable(awr_wdata)))
        else $error("array write changed while stalled");

    // R5
    wb_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WB && awr_fire && !dirty_single) |=> (awr_blk > $past(awr_blk)))
        else $error("write-back order not ascending");

    // R6
    sense_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sns_valid) |-> !dirty_any)
        else $error("sensing began with modified blocks pending");

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (sns_valid || awr_valid) |-> !req_ready)
        else $error("request port ready while busy");
endmodule

// File: tb/nvm_rowbuf_ctrl_tb_top.sv
module nvm_rowbuf_ctrl_tb_top;
    import nvrb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic bypass_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [NVRB_ROW_W-1:0]  req_row = '0;
    logic [NVRB_IDX_W-1:0]  req_blk = '0;
    logic [NVRB_DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, sns_valid, awr_valid;
    logic sns_ready = 1'b1, awr_ready = 1'b1;
    logic [NVRB_DATA_W-1:0] rsp_rdata, awr_wdata;
    logic [NVRB_DATA_W-1:0] sns_rdata = '0;
    logic [NVRB_ROW_W-1:0]  sns_row, awr_row;
    logic [NVRB_IDX_W-1:0]  sns_blk, awr_blk;

    nvm_rowbuf_ctrl dut_i (
        .clk(clk), .rst(rst), .bypass_mode(bypass_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_blk(req_blk), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sns_valid(sns_valid), .sns_ready(sns_ready), .sns_row(sns_row),
        .sns_blk(sns_blk), .sns_rdata(sns_rdata),
        .awr_valid(awr_valid), .awr_ready(awr_ready), .awr_row(awr_row),
        .awr_blk(awr_blk), .awr_wdata(awr_wdata)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    bit stall = 1'b0;
    logic [NVRB_DATA_W-1:0] mem [int];
    int wl_row[$], wl_blk[$];
    logic [NVRB_DATA_W-1:0] wl_dat[$];
    int sl_blk[$];
    int overlap = 0, busyrdy = 0, rsp_cnt = 0, rsp_cyc = 0;
    int first_sns_cyc = -1, last_sns_cyc = 0, last_wr_cyc = 0, acc_cyc = 0;
    logic [NVRB_DATA_W-1:0] rsp_dat = '0;

    function automatic logic [NVRB_DATA_W-1:0] pat(input int row, input int blk);
        logic [7:0] r8 = 8'(row);
        logic [4:0] b5 = 5'(blk);
        return {16{r8, 3'b000, b5, 16'hC3A5}};
    endfunction

    function automatic logic [NVRB_DATA_W-1:0] model_rd(input int row, input int blk);
        int key = row * 32 + blk;
        return mem.exists(key) ? mem[key] : pat(row, blk);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // array model and monitor, all on the falling edge
    always @(negedge clk) begin
        awr_ready = stall ? cyc[0] : 1'b1;
        sns_ready = stall ? ~cyc[0] : 1'b1;
        sns_rdata = model_rd(int'(sns_row), int'(sns_blk));
        if (awr_valid && sns_valid) overlap++;
        if ((awr_valid || sns_valid) && req_ready) busyrdy++;
        if (sns_valid && first_sns_cyc < 0) first_sns_cyc = cyc;
        if (awr_valid && awr_ready) begin
            wl_row.push_back(int'(awr_row));
            wl_blk.push_back(int'(awr_blk));
            wl_dat.push_back(awr_wdata);
            mem[int'(awr_row) * 32 + int'(awr_blk)] = awr_wdata;
            last_wr_cyc = cyc;
        end
        if (sns_valid && sns_ready) begin
            sl_blk.push_back(int'(sns_blk));
            last_sns_cyc = cyc;
        end
        if (rsp_valid) begin
            rsp_cnt++;
            rsp_cyc = cyc;
            rsp_dat = rsp_rdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [NVRB_DATA_W-1:0] act,
                       input logic [NVRB_DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        wl_row.delete(); wl_blk.delete(); wl_dat.delete(); sl_blk.delete();
        overlap = 0; busyrdy = 0; rsp_cnt = 0; first_sns_cyc = -1;
    endtask

    task automatic issue(input logic wr, input logic byp, input int row, input int blk,
                         input logic [NVRB_DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; bypass_mode = byp;
        req_row = NVRB_ROW_W'(row); req_blk = NVRB_IDX_W'(blk); req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk); #1;
        while (!req_ready && n < 2000) begin
            @(negedge clk); #1;
            n++;
        end
        @(negedge clk); #1;
    endtask

    task automatic read_hit(input int row, input int blk, input logic [NVRB_DATA_W-1:0] exp,
                            input string req);
        clear_logs();
        issue(1'b0, 1'b0, row, blk, '0);
        wait_idle();
        chk(rsp_cnt == 1 && rsp_cyc == acc_cyc + 1, req, rsp_cyc, acc_cyc + 1);
        chk(rsp_dat == exp, req, rsp_dat, exp);
        chk(sl_blk.size() == 0 && wl_row.size() == 0, req, sl_blk.size() + wl_row.size(), 0);
    endtask

    task automatic t_reset();
        chk(req_ready && !rsp_valid && !awr_valid && !sns_valid, "R1",
            {req_ready, rsp_valid, awr_valid, sns_valid}, 4'b1000);
    endtask

    task automatic t_clean_miss();
        bit asc = 1'b1;
        clear_logs();
        issue(1'b0, 1'b0, 5, 3, '0);
        wait_idle();
        chk(wl_row.size() == 0, "R1 R4 no write-back", wl_row.size(), 0);
        chk(first_sns_cyc == acc_cyc + 1, "R4 sense start", first_sns_cyc, acc_cyc + 1);
        for (int i = 0; i < sl_blk.size(); i++) if (sl_blk[i] != i) asc = 1'b0;
        chk(sl_blk.size() == 32 && asc, "R7 sense order", sl_blk.size(), 32);
        chk(rsp_cnt == 1 && rsp_cyc == last_sns_cyc + 2, "R7 response cycle", rsp_cyc, last_sns_cyc + 2);
        chk(rsp_dat == pat(5, 3), "R7 response data", rsp_dat, pat(5, 3));
        chk(busyrdy == 0, "R10 busy", busyrdy, 0);
    endtask

    task automatic t_write_hits();
        clear_logs();
        issue(1'b1, 1'b0, 5, 30, pat(90, 30));
        issue(1'b1, 1'b0, 5, 1, pat(91, 1));
        issue(1'b1, 1'b0, 5, 2, pat(92, 2));
        issue(1'b1, 1'b0, 5, 9, pat(93, 9));
        wait_idle();
        chk(wl_row.size() == 0 && sl_blk.size() == 0, "R3 no array access",
            wl_row.size() + sl_blk.size(), 0);
        read_hit(5, 9, pat(93, 9), "R3 read after write");
    endtask

    task automatic t_bypass_hit();
        clear_logs();
        issue(1'b1, 1'b1, 5, 9, pat(94, 9));
        wait_idle();
        chk(wl_row.size() == 1 && sl_blk.size() == 0, "R9 bypass traffic",
            wl_row.size(), 1);
        if (wl_row.size() == 1)
            chk(wl_row[0] == 5 && wl_blk[0] == 9 && wl_dat[0] == pat(94, 9),
                "R9 bypass write", wl_dat[0], pat(94, 9));
        read_hit(5, 9, pat(94, 9), "R9 coherent buffer");
    endtask

    task automatic t_bypass_miss();
        clear_logs();
        issue(1'b1, 1'b1, 8, 0, pat(95, 0));
        wait_idle();
        chk(wl_row.size() == 1 && sl_blk.size() == 0, "R9 bypass miss traffic",
            wl_row.size(), 1);
        if (wl_row.size() == 1)
            chk(wl_row[0] == 8 && wl_blk[0] == 0, "R9 bypass miss address", wl_row[0], 8);
        read_hit(5, 0, pat(5, 0), "R9 open row kept");
    endtask

    task automatic t_dirty_miss();
        clear_logs();
        stall = 1'b1;
        issue(1'b0, 1'b0, 6, 11, '0);
        wait_idle();
        stall = 1'b0;
        chk(wl_row.size() == 3, "R5 write-back count", wl_row.size(), 3);
        if (wl_row.size() == 3) begin
            chk(wl_blk[0] == 1 && wl_blk[1] == 2 && wl_blk[2] == 30, "R5 order",
                {wl_blk[0], wl_blk[1], wl_blk[2]}, {32'd1, 32'd2, 32'd30});
            chk(wl_row[0] == 5 && wl_dat[0] == pat(91, 1) && wl_dat[2] == pat(90, 30),
                "R5 data", wl_dat[2], pat(90, 30));
        end
        chk(overlap == 0 && first_sns_cyc > last_wr_cyc, "R6 no overlap", first_sns_cyc, last_wr_cyc + 1);
        chk(rsp_dat == pat(6, 11) && rsp_cyc == last_sns_cyc + 2, "R7 data after write-back",
            rsp_dat, pat(6, 11));
        chk(busyrdy == 0, "R10 busy during write-back", busyrdy, 0);
    endtask

    task automatic t_write_miss();
        clear_logs();
        issue(1'b1, 1'b0, 7, 4, pat(96, 4));
        wait_idle();
        chk(sl_blk.size() == 32 && wl_row.size() == 0 && rsp_cnt == 0, "R8 open then merge",
            sl_blk.size(), 32);
        read_hit(7, 4, pat(96, 4), "R8 merged data");
        clear_logs();
        issue(1'b0, 1'b0, 5, 30, '0);
        wait_idle();
        chk(wl_row.size() == 1, "R8 merged block written back", wl_row.size(), 1);
        if (wl_row.size() == 1)
            chk(wl_row[0] == 7 && wl_blk[0] == 4 && wl_dat[0] == pat(96, 4), "R5 R8 write-back",
                wl_dat[0], pat(96, 4));
        chk(rsp_dat == pat(90, 30), "R5 array holds written-back block", rsp_dat, pat(90, 30));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_clean_miss();
        read_hit(5, 7, pat(5, 7), "R2 read hit");
        t_write_hits();
        t_bypass_hit();
        t_bypass_miss();
        t_dirty_miss();
        t_write_miss();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule